// File: doc/BRIEF.md
# Paged Boot ROM Read Bridge

This block connects a 32-bit host request/response port to a byte-wide external parallel ROM. The ROM is seen by the host through a window of 16K bytes. An internal page pointer picks which 16K page of the ROM that window shows. A host read of the window makes four back-to-back byte fetches from the ROM, lowest byte first. Each fetch holds chip select low for a fixed number of wait cycles. The four bytes are packed into one little-endian word and returned on the response channel.

Host writes never reach the ROM. A write to the window only moves the page pointer forward by one page. The pointer stops at the last page and goes back to page 0 only on reset. The low ROM address pins also act as board strap inputs. While reset is held, the block leaves those pins undriven and keeps sampling them. The value present when reset is released stays in a board configuration register, which the host can read.

Both host channels are valid/ready. A request is taken in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the bridge is idle. A response stays on `rsp_valid`/`rsp_data` without change until the host raises `rsp_ready`. Writes produce no response.

Top module: `paged_rom_bridge`

## Requirements
- R1: `req_ready` is high only when the bridge is out of reset and has no read in flight or response pending. A request is accepted in a cycle where `req_valid` and `req_ready` are both high.
- R2: An accepted window read (`req_write`=0, `req_cfg`=0) performs four fetches in the cycles that follow. Fetch k (k = 0..3) lasts ACCESS_WAIT cycles and drives `rom_addr` = {page, `req_addr`[13:2], k[1:0]}.
- R3: The response word carries fetched byte k in bits 8k+7:8k. Bits 1:0 of `req_addr` are ignored.
- R4: For a window read, `rsp_valid` rises exactly 4*ACCESS_WAIT cycles after the accepting edge. For a configuration read (`req_cfg`=1), it rises on the first edge after acceptance.
- R5: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold. The response is consumed on the first edge where `rsp_ready` is high, and `req_ready` returns in the next cycle.
- R6: An accepted window write (`req_write`=1, `req_cfg`=0) raises the page by one unless it is already NUM_PAGES-1, where it stays. The write gives no response and leaves `rom_cs_n` high.
- R7: Reset puts the page back to 0. The first window read after reset uses ROM addresses below 16384.
- R8: The board configuration register holds the value of `rom_addr_in` from the last clock edge of reset. A configuration read returns it zero-extended in `rsp_data`[7:0]. Writes with `req_cfg`=1 do not change it.
- R9: `rom_addr_oe` is low during reset and goes high on the first edge after reset is released.
- R10: `rom_cs_n` is low only during the fetch cycles of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cfg | input | 1 | 1 = board configuration register, 0 = ROM window |
| req_addr | input | PAGE_AW (14) | Byte offset in the window; bits 1:0 ignored |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_data | output | 32 | Read data |
| rom_addr | output | ROM_AW (16) | ROM byte address |
| rom_addr_oe | output | 1 | Output enable for the ROM address pins |
| rom_addr_in | input | STRAP_W (8) | Value read back from the low ROM address pins (straps) |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_data | input | 8 | ROM data byte |

## Verification
The assertions rely on the host keeping `req_write`, `req_cfg` and `req_addr` stable while `req_valid` waits for `req_ready`. They also rely on the ROM presenting a settled byte by the last wait cycle of each fetch. The bench changes request fields only on falling edges, and only before a request or after it has been accepted. Its ROM stand-in is a combinational function of `rom_addr` that is gated by chip select. Strap values change only while reset is released, so the value sampled at the last reset edge is the intended one.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } prb_state_e;

  localparam int unsigned BYTES_PER_WORD = 4;
  localparam int unsigned HOST_DW        = 32;
endpackage

// File: rtl/prb_page_ctr.sv
module prb_page_ctr #(
  parameter int unsigned NUM_PAGES = 4,
  parameter int unsigned PW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] page
);
  localparam logic [PW-1:0] LAST_PAGE = PW'(NUM_PAGES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page <= '0;
    end else if (adv && (page != LAST_PAGE)) begin
      page <= page + 1'b1;
    end
  end
endmodule

// File: rtl/prb_strap.sv
module prb_strap #(
  parameter int unsigned STRAP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] pins_in,
  output logic [STRAP_W-1:0] board_cfg,
  output logic               pins_oe
);
  // Sampled on every reset edge; the last one before release wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      board_cfg <= pins_in;
    end
  end

  always_ff @(posedge clk) begin
    pins_oe <= rst_n;
  end
endmodule

// File: rtl/prb_fetch.sv
module prb_fetch #(
  parameter int unsigned PAGE_AW     = 14,
  parameter int unsigned PW          = 2,
  parameter int unsigned ACCESS_WAIT = 25
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [PAGE_AW-3:0]        start_off,
  input  logic [PW-1:0]             page,
  input  logic [7:0]                rom_data,
  output logic [PW+PAGE_AW-1:0]     rom_addr,
  output logic                      rom_cs_n,
  output logic                      done,
  output logic [prb_pkg::HOST_DW-1:0] word
);
  localparam int unsigned WC_W   = (ACCESS_WAIT > 1) ? $clog2(ACCESS_WAIT) : 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(ACCESS_WAIT - 1);
  localparam int unsigned LANES  = prb_pkg::BYTES_PER_WORD;

  logic              busy;
  logic [1:0]        k;
  logic [WC_W-1:0]   wcnt;
  logic [PAGE_AW-3:0] off_q;
  logic              last_wait;
  logic              capture;

  assign last_wait = (wcnt == WC_LAST);
  assign capture   = busy && last_wait;
  assign done      = capture && (k == 2'd3);
  assign rom_cs_n  = !busy;
  assign rom_addr  = {page, off_q, k};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      k     <= '0;
      wcnt  <= '0;
      off_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      k     <= '0;
      wcnt  <= '0;
      off_q <= start_off;
    end else if (busy) begin
      if (last_wait) begin
        wcnt <= '0;
        k    <= k + 1'b1;
        if (k == 2'd3) busy <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word[lane*8 +: 8] <= '0;
      end else if (capture && (k == 2'(lane))) begin
        word[lane*8 +: 8] <= rom_data;
      end
    end
  end
endmodule

// File: rtl/paged_rom_bridge.sv
module paged_rom_bridge #(
  parameter int unsigned PAGE_AW     = 14,
  parameter int unsigned NUM_PAGES   = 4,
  parameter int unsigned ACCESS_WAIT = 25,
  parameter int unsigned STRAP_W     = 8,
  localparam int unsigned PW         = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int unsigned ROM_AW     = PW + PAGE_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_cfg,
  input  logic [PAGE_AW-1:0] req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_data,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic               rom_addr_oe,
  input  logic [STRAP_W-1:0] rom_addr_in,
  output logic               rom_cs_n,
  input  logic [7:0]         rom_data
);
  import prb_pkg::*;

  prb_state_e        state;
  logic              sel_cfg;
  logic              accept;
  logic              fetch_start;
  logic              page_adv;
  logic              fetch_done;
  logic [31:0]       fetch_word;
  logic [PW-1:0]     page_q;
  logic [STRAP_W-1:0] board_cfg;

  assign req_ready   = rst_n && (state == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign fetch_start = accept && !req_write && !req_cfg;
  assign page_adv    = accept &&  req_write && !req_cfg;
  assign rsp_valid   = (state == ST_RESP);
  assign rsp_data    = !rsp_valid ? '0 :
                       sel_cfg    ? 32'(board_cfg) : fetch_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sel_cfg <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept && !req_write) begin
          state   <= req_cfg ? ST_RESP : ST_FETCH;
          sel_cfg <= req_cfg;
        end
        ST_FETCH: if (fetch_done) state <= ST_RESP;
        ST_RESP:  if (rsp_ready)  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  prb_page_ctr #(.NUM_PAGES(NUM_PAGES), .PW(PW)) u_page (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (page_adv),
    .page (page_q)
  );

  prb_strap #(.STRAP_W(STRAP_W)) u_strap (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_in  (rom_addr_in),
    .board_cfg(board_cfg),
    .pins_oe  (rom_addr_oe)
  );

  prb_fetch #(.PAGE_AW(PAGE_AW), .PW(PW), .ACCESS_WAIT(ACCESS_WAIT)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fetch_start),
    .start_off(req_addr[PAGE_AW-1:2]),
    .page     (page_q),
    .rom_data (rom_data),
    .rom_addr (rom_addr),
    .rom_cs_n (rom_cs_n),
    .done     (fetch_done),
    .word     (fetch_word)
  );
endmodule

// File: rtl/prb_checker.sv
module prb_checker #(
  parameter int unsigned ROM_AW = 16,
  parameter int unsigned PW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_cfg,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_data,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_addr_oe,
  input logic              rom_cs_n,
  input logic [PW-1:0]     page_q
);
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R1
  AST_FETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !req_cfg) |=> (!rom_cs_n && rom_addr[1:0] == 2'd0)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && $past(!rom_cs_n)) |-> $stable(rom_addr[ROM_AW-1:2])); // R2
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R5
  AST_WRITE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> rom_cs_n); // R6
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (page_q == $past(page_q) || page_q == $past(page_q) + 1'b1)); // R6
  AST_PINS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rom_addr_oe); // R9
  AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || req_ready) |-> rom_cs_n); // R10
endmodule

bind paged_rom_bridge prb_checker #(.ROM_AW(ROM_AW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_cfg    (req_cfg),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rom_addr   (rom_addr),
  .rom_addr_oe(rom_addr_oe),
  .rom_cs_n   (rom_cs_n),
  .page_q     (page_q)
);

// File: tb/paged_rom_bridge_test.sv
module paged_rom_bridge_test;
  localparam int W  = 25;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_cfg = 1'b0;
  logic [13:0] req_addr = '0;
  logic        rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, rom_addr_oe, rom_cs_n;
  logic [31:0] rsp_data;
  logic [15:0] rom_addr;
  logic [7:0]  rom_addr_in, rom_data, strap_val = 8'hA6;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0, started = 0;

  // model state: 0 idle, 1 fetch, 2 response
  int m_st = 0, m_cnt = 0, m_page = 0, m_off = 0, m_sel = 0, m_oe = 0;
  logic [7:0] m_strap = '0;

  always #2 clk = ~clk;

  function automatic logic [7:0] rom_f(input int a);
    logic [15:0] v;
    v = 16'(a);
    return v[7:0] ^ (v[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  assign rom_data    = rom_cs_n ? 8'h00 : rom_f(int'(rom_addr));
  assign rom_addr_in = rom_addr_oe ? rom_addr[7:0] : strap_val;

  paged_rom_bridge uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cfg(req_cfg), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rom_addr(rom_addr), .rom_addr_oe(rom_addr_oe), .rom_addr_in(rom_addr_in),
    .rom_cs_n(rom_cs_n), .rom_data(rom_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    started = 1;
    cyc++;
    m_oe = rst_n ? 1 : 0;
    if (!rst_n) begin
      m_st = 0; m_page = 0; m_strap = strap_val; m_sel = 0;
    end else begin
      case (m_st)
        0: if (req_valid) begin
          if (req_write) begin
            if (!req_cfg && m_page < NP - 1) m_page++;
          end else if (req_cfg) begin
            m_st = 2; m_sel = 1;
          end else begin
            m_st = 1; m_cnt = 0; m_off = int'(req_addr[13:2]); m_sel = 0;
          end
        end
        1: begin
          m_cnt++;
          if (m_cnt == 4 * W) m_st = 2;
        end
        default: if (rsp_ready) m_st = 0;
      endcase
    end
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      logic [31:0] exp_w;
      int base;
      base = m_page * 16384 + m_off * 4;
      for (int i = 0; i < 4; i++) exp_w[i*8 +: 8] = rom_f(base + i);
      check("R1 req_ready", 32'(req_ready), 32'((m_st == 0) && rst_n));
      check("R4 rsp_valid", 32'(rsp_valid), 32'(m_st == 2));
      check("R10 rom_cs_n", 32'(rom_cs_n), 32'(m_st != 1));
      check("R9 rom_addr_oe", 32'(rom_addr_oe), 32'(m_oe));
      if (m_st == 1)
        check("R2 R6 R7 rom_addr", 32'(rom_addr), 32'(base + m_cnt / W));
      if (m_st == 2) begin
        if (m_sel != 0) check("R8 board cfg", rsp_data, 32'(m_strap));
        else            check("R3 R5 rsp_data", rsp_data, exp_w);
      end
    end
  end

  task automatic issue(input bit wr, input bit cfg, input logic [13:0] a);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_cfg = cfg; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic host_read(input bit cfg, input logic [13:0] a, input int stall);
    issue(0, cfg, a);
    while (!rsp_valid) @(negedge clk);
    repeat (stall) @(negedge clk);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic do_reset(input logic [7:0] s);
    @(negedge clk);
    strap_val = s;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R9 oe low in reset", 32'(rom_addr_oe), 32'(0));
    check("R1 ready low in reset", 32'(req_ready), 32'(0));
    rst_n = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    host_read(1, 14'h0, 0);             // R8 strap readback
    issue(1, 1, 14'h0);                 // R8 write to cfg ignored
    host_read(1, 14'h0, 2);
    host_read(0, 14'h0000, 0);          // R7 page 0 after reset
    host_read(0, 14'h3FFF, 3);          // R3 low bits ignored, R5 stall
    host_read(0, 14'h1236, 1);
    issue(1, 0, 14'h0);                 // R6 advance to page 1
    host_read(0, 14'h0104, 0);
    for (int i = 0; i < 5; i++) issue(1, 0, 14'h0); // R6 saturate at last page
    host_read(0, 14'h2AA8, 4);
    do_reset(8'h3C);                    // R7 R8 second reset
    host_read(1, 14'h0, 0);
    host_read(0, 14'h0040, 0);
    repeat (3) @(negedge clk);
    report();
  end
endmodule